// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

This block sits in a display scanout path, between the frame-memory fetch and the video output. On each cycle it may take one pixel: its screen coordinates and the 8-bit colour index read from frame memory. It returns the 24-bit colour to show at that spot. A 64x64 hardware pointer is laid over the picture. Each pointer pixel holds a 2-bit code in a pattern store of 16-bit words, with eight codes to a word. Code zero lets the underlying picture show through. The three other codes choose among three pointer colours.

The mixer presents two read addresses in the same cycle as the pixel: one into the pattern store and one into the main colour lookup table. Both stores are synchronous and return data one cycle later. The three pointer colours come in as a flat 72-bit bus from their holding registers. The result is registered once more, so a pixel appears at the output exactly two clocks after it was accepted, together with its coordinates and a valid flag. Register programming and scanout addressing belong to neighbouring blocks.

Top module: `cursor_overlay_mixer`

## Requirements
- R1: While reset is high and during the first two cycles after it, `out_valid` is 0.
- R2: `out_valid`, `out_x` and `out_y` repeat `in_valid`, `in_x` and `in_y` from exactly two clock cycles earlier, back-to-back pixels included.
- R3: A pixel outside the pointer square outputs the main-table entry for its index. `pal_addr` equals `in_index` in the cycle the pixel is presented. The table word carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: The pointer corner is read from `cur_pos`: x in bits 23:12 and y in bits 11:0. For a pixel inside the square with row offset r and column offset c, `pat_addr` in the same cycle is r*8 + c/8.
- R5: The pixel's code is bits [2*(c mod 8)+1 : 2*(c mod 8)] of the pattern word, so the lowest bit pair is the leftmost of each group of eight.
- R6: Code 0 is transparent and outputs the main-table entry for the pixel's index.
- R7: Codes 1, 2 and 3 output pointer colour 0, 1 and 2. Colour k sits at `cur_colors[24k+23:24k]`.
- R8: When `cur_disable` is 1, every pixel outputs its main-table entry.
- R9: The square covers x from cx to cx+63 and y from cy to cy+63, inclusive. The bounds are compared with one extra bit, so a corner near 4095 never wraps onto small coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_index | input | 8 | Colour index from frame memory |
| cur_pos | input | 24 | Pointer corner, x in 23:12, y in 11:0 |
| cur_disable | input | 1 | Suppresses the pointer |
| pat_addr | output | 9 | Pattern store word address |
| pat_rdata | input | 16 | Pattern word, one cycle after address |
| pal_addr | output | 8 | Main table address |
| pal_rdata | input | 24 | Main table RGB, one cycle after address |
| cur_colors | input | 72 | Three pointer colours, colour 0 lowest |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 12 | Output pixel column |
| out_y | output | 12 | Output pixel row |
| out_rgb | output | 24 | Output colour |

## Verification
The checker assumes both read stores answer exactly one cycle after the address and hold their data otherwise. It also assumes `cur_pos`, `cur_disable` and `cur_colors` stay steady while a pixel is in flight. The bench models the stores as one-cycle synchronous reads and changes the pointer settings only once the pipeline has drained. The expected colour model works only from the bit positions stated in the requirements.

// File: rtl/cursor_mix_pkg.sv
package cursor_mix_pkg;

    localparam int COORD_W        = 12;
    localparam int IDX_W          = 8;
    localparam int CHAN_W         = 8;
    localparam int RGB_W          = 3 * CHAN_W;
    localparam int CUR_DIM        = 64;
    localparam int CODE_W         = 2;
    localparam int PAT_W          = 16;
    localparam int CUR_COLORS     = 3;
    localparam int CODES_PER_WORD = PAT_W / CODE_W;
    localparam int OFF_W          = $clog2(CUR_DIM);
    localparam int COL_LO_W       = $clog2(CODES_PER_WORD);
    localparam int PAT_AW         = 2 * OFF_W - COL_LO_W;
    localparam int POS_W          = 2 * COORD_W;

    typedef logic [RGB_W-1:0]   rgb_t;
    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [CODE_W-1:0]  code_t;

    typedef struct packed {
        logic   valid;
        coord_t x;
        coord_t y;
    } pix_tag_t;

    typedef struct packed {
        pix_tag_t              tag;
        logic                  hit;
        logic [COL_LO_W-1:0]   col_lo;
    } stage1_t;

    typedef struct packed {
        pix_tag_t tag;
        rgb_t     rgb;
    } stage2_t;

    // One-axis window test, widened by one bit so the upper bound cannot wrap.
    function automatic logic in_span(input coord_t p, input coord_t corner);
        logic [COORD_W:0] pe;
        logic [COORD_W:0] lo;
        logic [COORD_W:0] hi;
        pe = {1'b0, p};
        lo = {1'b0, corner};
        hi = lo + (COORD_W + 1)'(CUR_DIM);
        return (pe >= lo) && (pe < hi);
    endfunction

    // Pick the code for one column out of a packed pattern word.
    function automatic code_t code_at(input logic [PAT_W-1:0] word,
                                      input logic [COL_LO_W-1:0] col);
        return word[col * CODE_W +: CODE_W];
    endfunction

endpackage

// File: rtl/cursor_window.sv
module cursor_window
    import cursor_mix_pkg::*;
(
    input  coord_t                pix_x,
    input  coord_t                pix_y,
    input  logic [POS_W-1:0]      pos,
    input  logic                  disable_cur,
    output logic                  hit,
    output logic [PAT_AW-1:0]     word_addr,
    output logic [COL_LO_W-1:0]   col_lo
);
    coord_t corner_x;
    coord_t corner_y;
    coord_t dx;
    coord_t dy;

    always_comb begin
        corner_x  = pos[POS_W-1:COORD_W];
        corner_y  = pos[COORD_W-1:0];
        dx        = pix_x - corner_x;
        dy        = pix_y - corner_y;
        hit       = !disable_cur && in_span(pix_x, corner_x) && in_span(pix_y, corner_y);
        word_addr = {dy[OFF_W-1:0], dx[OFF_W-1:COL_LO_W]};
        col_lo    = dx[COL_LO_W-1:0];
    end
endmodule

// File: rtl/cursor_color_sel.sv
module cursor_color_sel
    import cursor_mix_pkg::*;
(
    input  logic                        hit,
    input  logic [COL_LO_W-1:0]         col_lo,
    input  logic [PAT_W-1:0]            pat_word,
    input  rgb_t                        base_rgb,
    input  logic [CUR_COLORS*RGB_W-1:0] cur_colors,
    output rgb_t                        rgb
);
    localparam int SLOTS = 2 ** CODE_W;

    rgb_t  slot [SLOTS];
    code_t code;
    code_t sel;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < CUR_COLORS) begin : g_used
            assign slot[g] = cur_colors[g*RGB_W +: RGB_W];
        end else begin : g_unused
            assign slot[g] = '0;
        end
    end

    always_comb begin
        code = code_at(pat_word, col_lo);
        sel  = code - CODE_W'(1);
        rgb  = base_rgb;
        if (hit && code != '0) begin
            rgb = slot[sel];
        end
    end
endmodule

// File: rtl/cursor_overlay_mixer.sv
module cursor_overlay_mixer
    import cursor_mix_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [11:0] in_x,
    input  logic [11:0] in_y,
    input  logic [7:0]  in_index,
    input  logic [23:0] cur_pos,
    input  logic        cur_disable,
    output logic [8:0]  pat_addr,
    input  logic [15:0] pat_rdata,
    output logic [7:0]  pal_addr,
    input  logic [23:0] pal_rdata,
    input  logic [71:0] cur_colors,
    output logic        out_valid,
    output logic [11:0] out_x,
    output logic [11:0] out_y,
    output logic [23:0] out_rgb
);
    logic                hit0;
    logic [COL_LO_W-1:0] col0;
    stage1_t             s1_q;
    stage2_t             s2_q;
    rgb_t                mixed;

    cursor_window u_window (
        .pix_x       (in_x),
        .pix_y       (in_y),
        .pos         (cur_pos),
        .disable_cur (cur_disable),
        .hit         (hit0),
        .word_addr   (pat_addr),
        .col_lo      (col0)
    );

    assign pal_addr = in_index;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.tag.valid <= in_valid;
            s1_q.tag.x     <= in_x;
            s1_q.tag.y     <= in_y;
            s1_q.hit       <= hit0;
            s1_q.col_lo    <= col0;
        end
    end

    cursor_color_sel u_sel (
        .hit        (s1_q.hit),
        .col_lo     (s1_q.col_lo),
        .pat_word   (pat_rdata),
        .base_rgb   (pal_rdata),
        .cur_colors (cur_colors),
        .rgb        (mixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.tag <= s1_q.tag;
            s2_q.rgb <= mixed;
        end
    end

    assign out_valid = s2_q.tag.valid;
    assign out_x     = s2_q.tag.x;
    assign out_y     = s2_q.tag.y;
    assign out_rgb   = s2_q.rgb;
endmodule

// File: rtl/cursor_overlay_mixer_chk.sv
module cursor_overlay_mixer_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [11:0] in_x,
    input logic [11:0] in_y,
    input logic [23:0] cur_pos,
    input logic        cur_disable,
    input logic [8:0]  pat_addr,
    input logic [23:0] pal_rdata,
    input logic        out_valid,
    input logic [11:0] out_x,
    input logic [11:0] out_y,
    input logic [23:0] out_rgb
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd2) |-> !out_valid);

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_coord_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && out_valid) |->
            (out_x == $past(in_x, 2) && out_y == $past(in_y, 2)));

    assert_corner_word_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cur_disable && in_x == cur_pos[23:12] && in_y == cur_pos[11:0])
            |-> (pat_addr == 9'd0));

    assert_disabled_base_R8: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && $past(in_valid, 2) && $past(cur_disable, 2))
            |-> (out_rgb == $past(pal_rdata, 1)));
endmodule

bind cursor_overlay_mixer cursor_overlay_mixer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_x        (in_x),
    .in_y        (in_y),
    .cur_pos     (cur_pos),
    .cur_disable (cur_disable),
    .pat_addr    (pat_addr),
    .pal_rdata   (pal_rdata),
    .out_valid   (out_valid),
    .out_x       (out_x),
    .out_y       (out_y),
    .out_rgb     (out_rgb)
);

// File: tb/cursor_overlay_mixer_tb.sv
module cursor_overlay_mixer_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [71:0] CCOLS = {24'hFEDCBA, 24'hA0B0C0, 24'h102030};

    typedef struct packed {
        logic [11:0] x;
        logic [11:0] y;
        logic [7:0]  idx;
        logic [23:0] pos;
        logic        dis;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{12'd200,  12'd200,  8'd7,   {12'd100,  12'd50},   1'b0}, // R3 outside
        '{12'd100,  12'd50,   8'd9,   {12'd100,  12'd50},   1'b0}, // R4 corner
        '{12'd117,  12'd55,   8'd11,  {12'd100,  12'd50},   1'b0}, // R4 word 42
        '{12'd163,  12'd113,  8'd12,  {12'd100,  12'd50},   1'b0}, // R9 last inside
        '{12'd164,  12'd60,   8'd13,  {12'd100,  12'd50},   1'b0}, // R9 right edge
        '{12'd99,   12'd60,   8'd14,  {12'd100,  12'd50},   1'b0}, // R9 left edge
        '{12'd130,  12'd114,  8'd15,  {12'd100,  12'd50},   1'b0}, // R9 bottom edge
        '{12'd130,  12'd49,   8'd16,  {12'd100,  12'd50},   1'b0}, // R9 top edge
        '{12'd2,    12'd2,    8'd17,  {12'd4090, 12'd4090}, 1'b0}, // R9 no wrap
        '{12'd4095, 12'd4095, 8'd18,  {12'd4090, 12'd4090}, 1'b0}, // R9 far corner
        '{12'd100,  12'd50,   8'd19,  {12'd100,  12'd50},   1'b1}, // R8 disabled
        '{12'd140,  12'd80,   8'd20,  {12'd100,  12'd50},   1'b1}, // R8 disabled
        '{12'd0,    12'd0,    8'd255, {12'd0,    12'd0},    1'b0}  // R4 origin
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic [7:0]  in_index = '0;
    logic [23:0] cur_pos = '0;
    logic        cur_disable = 1'b0;
    logic [8:0]  pat_addr;
    logic [15:0] pat_rdata;
    logic [7:0]  pal_addr;
    logic [23:0] pal_rdata;
    logic        out_valid;
    logic [11:0] out_x;
    logic [11:0] out_y;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cursor_overlay_mixer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_index(in_index), .cur_pos(cur_pos), .cur_disable(cur_disable),
        .pat_addr(pat_addr), .pat_rdata(pat_rdata), .pal_addr(pal_addr),
        .pal_rdata(pal_rdata), .cur_colors(CCOLS), .out_valid(out_valid),
        .out_x(out_x), .out_y(out_y), .out_rgb(out_rgb)
    );

    function automatic logic [15:0] pat_fn(input logic [8:0] w);
        logic [15:0] h;
        h = 16'(w) * 16'h9E37;
        return (w == 9'd0) ? 16'hE4E4 : (h ^ 16'h5A3C);
    endfunction

    function automatic logic [23:0] pal_fn(input logic [7:0] i);
        return {i, i ^ 8'hFF, i ^ 8'h3C};
    endfunction

    // Synchronous one-cycle stores
    always_ff @(posedge clk) begin
        pat_rdata <= pat_fn(pat_addr);
        pal_rdata <= pal_fn(pal_addr);
    end

    function automatic bit inside_sq(input vec_t v);
        int cx, cy;
        cx = int'(v.pos[23:12]);
        cy = int'(v.pos[11:0]);
        return !v.dis && int'(v.x) >= cx && int'(v.x) <= cx + 63 &&
               int'(v.y) >= cy && int'(v.y) <= cy + 63;
    endfunction

    function automatic logic [8:0] exp_word(input vec_t v);
        int r, c;
        r = int'(v.y) - int'(v.pos[11:0]);
        c = int'(v.x) - int'(v.pos[23:12]);
        return 9'(r * 8 + c / 8);
    endfunction

    function automatic logic [23:0] exp_rgb(input vec_t v);
        int c, code;
        logic [15:0] w;
        if (!inside_sq(v)) return pal_fn(v.idx);
        c = int'(v.x) - int'(v.pos[23:12]);
        w = pat_fn(exp_word(v));
        code = int'((w >> ((c % 8) * 2)) & 16'h3);
        if (code == 0) return pal_fn(v.idx);
        return CCOLS[(code - 1) * 24 +: 24];
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        in_valid    = vld;
        in_x        = v.x;
        in_y        = v.y;
        in_index    = v.idx;
        cur_pos     = v.pos;
        cur_disable = v.dis;
    endtask

    task automatic run_one(input vec_t v, input string req);
        @(negedge clk);
        drive(v, 1'b1);
        #1;
        check("R3 pal_addr", 32'(pal_addr), 32'(v.idx));
        if (inside_sq(v)) check("R4 pat_addr", 32'(pat_addr), 32'(exp_word(v)));
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 valid", 32'(out_valid), 32'd1);
        check("R2 coords", {8'd0, out_x, out_y}, {8'd0, v.x, v.y});
        check(req, 32'(out_rgb), 32'(exp_rgb(v)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post reset", 32'(out_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i], "R3/R6/R7/R8/R9 rgb");
        end

        // R5 R6 R7: row 0 columns 0..7 read word 0 = E4E4, codes 0,1,2,3,0,1,2,3
        for (int c = 0; c < 8; c++) begin
            vec_t v;
            logic [23:0] e;
            v = '{12'(100 + c), 12'd50, 8'(40 + c), {12'd100, 12'd50}, 1'b0};
            case (c % 4)
                0: e = pal_fn(v.idx);
                1: e = 24'h102030;
                2: e = 24'hA0B0C0;
                default: e = 24'hFEDCBA;
            endcase
            run_one(v, "R5 rgb");
            check("R5 R6 R7 code colour", 32'(out_rgb), 32'(e));
        end

        // R2 back-to-back stream
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                check("R2 stream valid", 32'(out_valid), 32'(k - 2 < 4));
                if (k - 2 < 4) begin
                    check("R2 stream x", 32'(out_x), 32'(VECS[k - 2].x));
                    check("R2 stream rgb", 32'(out_rgb), 32'(exp_rgb(VECS[k - 2])));
                end
            end
            drive(VECS[k < 4 ? k : 0], k < 4);
        end

        // R1 reset mid-flight
        @(negedge clk);
        drive(VECS[1], 1'b1);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 flush", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 flush hold", 32'(out_valid), 32'd0);
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule